// File: doc/BRIEF.md
# Serial Converter Command Sequencer

This block is the digital front end of a serial successive-approximation converter. Everything runs on one system clock. The chip-select, serial clock and data line are sampled as synchronous inputs, and edges of the serial clock are found by comparing each sample with the one before it. While the device is selected and idle, the block waits for the first logic one on the data line. That one opens an 8-bit command. The command sets the input polarity, chooses between the serial clock and a fixed internal delay as the conversion timebase, chooses an operation, and loads three general-purpose port outputs.

For a conversion, the block counts falling serial-clock edges through a 24-edge or 32-edge frame. It raises a strobe for one serial period and then shifts a 14-bit result out, MSB first. The result comes from a parallel input that stands in for the analog core. A calibration is shown as a busy flag that lasts a fixed number of system clocks. A power-down is shown as a flag that stays set until the next command. Raising chip-select ends any operation in progress. After the device is selected again, a new command starts a fresh acquisition.

Top module: `adcseq_top`

## Requirements
- R1: A synchronous active-high reset clears port_out, cfg_unipolar, cfg_int_clk, cal_busy, pwr_down, strobe and dout to zero.
- R2: While cs_n is low and the block is idle, zeros sampled on rising sclk edges are ignored. The first one sampled is the start bit, and the next seven rising edges complete the command.
- R3: Command bit 6 drives cfg_unipolar (1 = unipolar). Bit 5 drives cfg_int_clk (1 = internal timebase). Bits 4:3 are the operation code. All of these update in the cycle after the eighth rising edge of the command.
- R4: port_out takes command bits 2:0 all at once when a command completes. At all other times it holds, including through power-down and calibration.
- R5: Operation 00 with the serial timebase gives a short frame. Falling edges are counted after the last command bit. strobe is high from falling edge 7 until falling edge 8, and the result MSB appears on dout at falling edge 8.
- R6: Operation 11 with the serial timebase gives a long frame. strobe is high from falling edge 15 until falling edge 16, and the MSB appears at falling edge 16.
- R7: The result is captured when strobe rises. It is sent MSB first on 14 successive falling edges. After that dout is low until the frame ends at falling edge 24 (short) or 32 (long), and then the block hunts for a start bit again.
- R8: Operation 01 holds cal_busy high for CAL_CYCLES system clocks and then returns to hunting.
- R9: Operation 10 sets pwr_down. Any later command with a different operation code clears it.
- R10: cs_n high ends a conversion or calibration and clears strobe and dout. A start bit after cs_n falls again begins a new acquisition.
- R11: With cfg_int_clk set, strobe rises INT_CYCLES system clocks after the command and the result is captured then. The next falling edge clears strobe and presents the MSB, and the frame then continues as in R5/R7.
- R12: While a conversion or calibration is running, ones on din are not taken as start bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock (sampled) |
| din | input | 1 | Serial command data |
| result_in | input | RES_W | Parallel conversion result from the analog core |
| dout | output | 1 | Serial result data |
| strobe | output | 1 | End-of-acquisition strobe |
| port_out | output | 3 | General-purpose port outputs |
| cfg_unipolar | output | 1 | Polarity selection from the last command |
| cfg_int_clk | output | 1 | Timebase selection from the last command |
| cal_busy | output | 1 | Calibration in progress |
| pwr_down | output | 1 | Software power-down flag |

## Verification
A miscounted falling-edge counter moves strobe and the MSB by whole serial periods. The shifted word read from dout then differs from result_in within the same frame. An error in start-bit framing mis-slices the command, so port_out and the configuration flags differ from the reference one system clock after the eighth rising edge. A stuck busy or sequence state shows up as a missing strobe, a lost next command or a cal_busy that never drops. The reference model is compared on every system clock, so each of these faults is flagged in the cycle it first reaches a port.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [1:0] {
        OP_SHORT = 2'b00,
        OP_CAL   = 2'b01,
        OP_PDN   = 2'b10,
        OP_LONG  = 2'b11
    } op_e;

    typedef struct packed {
        logic       start;
        logic       unipolar;
        logic       int_clk;
        op_e        op;
        logic [2:0] port;
    } cmd_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_INTWAIT,
        SQ_FRAME
    } seq_state_e;

    function automatic logic is_conv(op_e op);
        return (op == OP_SHORT) || (op == OP_LONG);
    endfunction

endpackage

// File: rtl/adcseq_edge.sv
module adcseq_edge (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign rise = ~cs_n & sclk & ~sclk_q;
    assign fall = ~cs_n & ~sclk & sclk_q;
endmodule

// File: rtl/adcseq_byte_rx.sv
module adcseq_byte_rx
    import adcseq_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rise,
    input  logic din,
    input  logic armed,
    output logic byte_valid,
    output cmd_t byte_out
);
    localparam int CW = $clog2(BYTE_W);

    logic              collecting;
    logic [CW-1:0]     cnt;
    logic [BYTE_W-2:0] sreg;
    logic              last_bit;

    assign last_bit   = (cnt == CW'(BYTE_W - 2));
    assign byte_valid = rise & collecting & last_bit;
    assign byte_out   = cmd_t'({sreg, din});

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            collecting <= 1'b0;
            cnt        <= '0;
            sreg       <= '0;
        end else if (rise) begin
            if (!collecting) begin
                if (armed && din) begin
                    collecting <= 1'b1;
                    cnt        <= '0;
                    sreg       <= (BYTE_W-1)'(1);
                end
            end else if (last_bit) begin
                collecting <= 1'b0;
            end else begin
                sreg <= {sreg[BYTE_W-3:0], din};
                cnt  <= cnt + 1'b1;
            end
        end
    end

    p_start_bit_r2: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> byte_out.start);
endmodule

// File: rtl/adcseq_conv.sv
module adcseq_conv
    import adcseq_pkg::*;
#(
    parameter int RES_W       = 14,
    parameter int SHORT_FRAME = 24,
    parameter int LONG_FRAME  = 32,
    parameter int INT_CYCLES  = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             fall,
    input  logic             start,
    input  logic             use_int,
    input  logic             long_sel,
    input  logic [RES_W-1:0] result_in,
    output logic             busy,
    output logic             strobe,
    output logic             dout
);
    localparam int FCW = $clog2(LONG_FRAME + 1);
    localparam int ICW = $clog2(INT_CYCLES + 1);
    localparam logic [FCW-1:0] SP_S = FCW'(SHORT_FRAME - RES_W - 3);
    localparam logic [FCW-1:0] SP_L = FCW'(LONG_FRAME - RES_W - 3);
    localparam logic [FCW-1:0] FL_S = FCW'(SHORT_FRAME);
    localparam logic [FCW-1:0] FL_L = FCW'(LONG_FRAME);

    seq_state_e       state;
    logic             long_q;
    logic [FCW-1:0]   fcnt, fnext, sp, fl;
    logic [ICW-1:0]   icnt;
    logic [RES_W-1:0] shreg;
    logic             in_data;

    always_comb begin
        fnext   = fcnt + 1'b1;
        sp      = long_q ? SP_L : SP_S;
        fl      = long_q ? FL_L : FL_S;
        in_data = (fnext > sp) && (fnext <= sp + FCW'(RES_W));
    end

    assign busy = (state != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            state  <= SQ_IDLE;
            strobe <= 1'b0;
            dout   <= 1'b0;
            fcnt   <= '0;
            icnt   <= '0;
            long_q <= 1'b0;
            shreg  <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        long_q <= long_sel;
                        fcnt   <= '0;
                        if (use_int) begin
                            state <= SQ_INTWAIT;
                            icnt  <= ICW'(INT_CYCLES - 1);
                        end else begin
                            state <= SQ_FRAME;
                        end
                    end
                end
                SQ_INTWAIT: begin
                    if (icnt == '0) begin
                        state  <= SQ_FRAME;
                        fcnt   <= sp;
                        strobe <= 1'b1;
                        shreg  <= result_in;
                    end else begin
                        icnt <= icnt - 1'b1;
                    end
                end
                SQ_FRAME: begin
                    if (fall) begin
                        fcnt <= fnext;
                        if (fnext == sp) begin
                            strobe <= 1'b1;
                            shreg  <= result_in;
                        end else if (fnext == sp + 1'b1) begin
                            strobe <= 1'b0;
                        end
                        if (in_data) begin
                            dout  <= shreg[RES_W-1];
                            shreg <= {shreg[RES_W-2:0], 1'b0};
                        end else begin
                            dout <= 1'b0;
                        end
                        if (fnext == fl) state <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    p_strobe_one_period_r5: assert property (@(posedge clk) disable iff (rst)
        (strobe && fall) |=> !strobe);
    p_dout_quiet_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_IDLE) |-> !dout);
    p_deselect_ends_r10: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!busy && !strobe && !dout));
    p_intwait_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_INTWAIT) |-> (!strobe && !dout));
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int RES_W       = 14,
    parameter int SHORT_FRAME = 24,
    parameter int LONG_FRAME  = 32,
    parameter int CAL_CYCLES  = 40,
    parameter int INT_CYCLES  = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic [RES_W-1:0] result_in,
    output logic             dout,
    output logic             strobe,
    output logic [2:0]       port_out,
    output logic             cfg_unipolar,
    output logic             cfg_int_clk,
    output logic             cal_busy,
    output logic             pwr_down
);
    localparam int CCW = $clog2(CAL_CYCLES + 1);

    logic           rise, fall;
    logic           byte_valid;
    cmd_t           cmd;
    logic           seq_busy;
    logic           armed;
    logic           conv_start;
    logic [CCW-1:0] cal_cnt;

    assign armed      = ~seq_busy & ~cal_busy;
    assign conv_start = byte_valid & is_conv(cmd.op);

    adcseq_edge u_edge (
        .clk (clk),
        .rst (rst),
        .cs_n(cs_n),
        .sclk(sclk),
        .rise(rise),
        .fall(fall)
    );

    adcseq_byte_rx #(.BYTE_W(8)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .rise      (rise),
        .din       (din),
        .armed     (armed),
        .byte_valid(byte_valid),
        .byte_out  (cmd)
    );

    adcseq_conv #(
        .RES_W      (RES_W),
        .SHORT_FRAME(SHORT_FRAME),
        .LONG_FRAME (LONG_FRAME),
        .INT_CYCLES (INT_CYCLES)
    ) u_conv (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .fall     (fall),
        .start    (conv_start),
        .use_int  (cmd.int_clk),
        .long_sel (cmd.op == OP_LONG),
        .result_in(result_in),
        .busy     (seq_busy),
        .strobe   (strobe),
        .dout     (dout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            port_out     <= '0;
            cfg_unipolar <= 1'b0;
            cfg_int_clk  <= 1'b0;
            pwr_down     <= 1'b0;
        end else if (byte_valid) begin
            port_out     <= cmd.port;
            cfg_unipolar <= cmd.unipolar;
            cfg_int_clk  <= cmd.int_clk;
            pwr_down     <= (cmd.op == OP_PDN);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            cal_busy <= 1'b0;
            cal_cnt  <= '0;
        end else if (byte_valid && cmd.op == OP_CAL) begin
            cal_busy <= 1'b1;
            cal_cnt  <= CCW'(CAL_CYCLES - 1);
        end else if (cal_busy) begin
            if (cal_cnt == '0) cal_busy <= 1'b0;
            else               cal_cnt  <= cal_cnt - 1'b1;
        end
    end

    p_port_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !byte_valid |=> $stable(port_out));
    p_no_start_while_busy_r12: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> (!seq_busy && !cal_busy));
    p_cal_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        cal_busy |-> !seq_busy);
    p_pdn_sets_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && cmd.op == OP_PDN) |=> pwr_down);
endmodule

// File: tb/sim_adcseq_top.sv
`timescale 1ns/100ps
module sim_adcseq_top;
    localparam int RES_W = 14;
    localparam int CAL_C = 40;
    localparam int INT_C = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic [RES_W-1:0] result_in = '0;
    logic dout, strobe, cfg_unipolar, cfg_int_clk, cal_busy, pwr_down;
    logic [2:0] port_out;

    always #2.5 clk = ~clk;

    adcseq_top #(.RES_W(RES_W), .CAL_CYCLES(CAL_C), .INT_CYCLES(INT_C)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .result_in(result_in), .dout(dout), .strobe(strobe),
        .port_out(port_out), .cfg_unipolar(cfg_unipolar),
        .cfg_int_clk(cfg_int_clk), .cal_busy(cal_busy), .pwr_down(pwr_down)
    );

    int vectors = 0;
    int miscompares = 0;

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int  m_prev, m_state, m_collect, m_nbits, m_byte, m_fcnt, m_icnt;
    int  m_cal, m_calcnt, m_dout, m_strobe, m_port, m_uni, m_intc, m_pd, m_long, m_word;

    always @(posedge clk) begin
        int rs, fl_e, n, sp, fr, armed, bytev, op;
        rs   = (!cs_n && sclk && !m_prev) ? 1 : 0;
        fl_e = (!cs_n && !sclk && m_prev) ? 1 : 0;
        bytev = 0;
        if (rst) begin
            m_prev = 0; m_state = 0; m_collect = 0; m_nbits = 0; m_byte = 0;
            m_fcnt = 0; m_icnt = 0; m_cal = 0; m_calcnt = 0; m_dout = 0;
            m_strobe = 0; m_port = 0; m_uni = 0; m_intc = 0; m_pd = 0;
            m_long = 0; m_word = 0;
        end else begin
            m_prev = sclk;
            if (cs_n) begin
                m_collect = 0; m_state = 0; m_strobe = 0; m_dout = 0; m_cal = 0;
            end else begin
                armed = (m_state == 0 && m_cal == 0) ? 1 : 0;
                if (rs) begin
                    if (!m_collect) begin
                        if (armed && din) begin m_collect = 1; m_nbits = 1; m_byte = 1; end
                    end else begin
                        m_byte = m_byte * 2 + din; m_nbits++;
                        if (m_nbits == 8) begin m_collect = 0; bytev = 1; end
                    end
                end
                sp = m_long ? 15 : 7;
                fr = m_long ? 32 : 24;
                if (m_state == 1) begin
                    if (m_icnt == 0) begin
                        m_state = 2; m_fcnt = sp; m_strobe = 1; m_word = result_in;
                    end else m_icnt--;
                end else if (m_state == 2 && fl_e) begin
                    n = m_fcnt + 1; m_fcnt = n;
                    if (n == sp) begin m_strobe = 1; m_word = result_in; end
                    else if (n == sp + 1) m_strobe = 0;
                    if (n > sp && n <= sp + RES_W) begin
                        m_dout = (m_word >> (RES_W - 1)) & 1;
                        m_word = (m_word << 1) & ((1 << RES_W) - 1);
                    end else m_dout = 0;
                    if (n == fr) m_state = 0;
                end
                if (m_cal) begin
                    if (m_calcnt == 0) m_cal = 0; else m_calcnt--;
                end
                if (bytev) begin
                    op = (m_byte >> 3) & 3;
                    m_port = m_byte & 7;
                    m_uni  = (m_byte >> 6) & 1;
                    m_intc = (m_byte >> 5) & 1;
                    m_pd   = (op == 2) ? 1 : 0;
                    if (op == 1) begin m_cal = 1; m_calcnt = CAL_C - 1; end
                    if (op == 0 || op == 3) begin
                        m_long = (op == 3) ? 1 : 0;
                        m_fcnt = 0;
                        if (m_intc) begin m_state = 1; m_icnt = INT_C - 1; end
                        else m_state = 2;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R7 dout", int'(dout), m_dout);
            chk("R5 strobe", int'(strobe), m_strobe);
            chk("R4 port_out", int'(port_out), m_port);
            chk("R3 cfg_unipolar", int'(cfg_unipolar), m_uni);
            chk("R3 cfg_int_clk", int'(cfg_int_clk), m_intc);
            chk("R9 pwr_down", int'(pwr_down), m_pd);
            chk("R8 cal_busy", int'(cal_busy), m_cal);
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            miscompares++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    logic cap_d [0:63];
    logic cap_s [0:63];

    task automatic pulse(input logic b, input int idx);
        sclk = 1'b0; din = b;
        @(negedge clk);
        cap_d[idx] = dout; cap_s[idx] = strobe;
        @(negedge clk);
        sclk = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_cmd(input int lead, input logic [7:0] b);
        for (int i = 0; i < lead; i++) pulse(1'b0, 0);
        for (int i = 7; i >= 0; i--) pulse(b[i], 0);
        din = 1'b0;
        @(negedge clk);
    endtask

    task automatic run(input int n, input int hi_until);
        for (int i = 1; i <= n; i++) pulse(i <= hi_until, i);
        din = 1'b0;
    endtask

    function automatic int word_at(input int first);
        int w = 0;
        for (int i = 0; i < RES_W; i++) w = w * 2 + int'(cap_d[first + i]);
        return w;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset port", int'(port_out), 0);
        chk("R1 reset flags", int'({cfg_unipolar, cfg_int_clk, cal_busy, pwr_down, strobe, dout}), 0);

        // R2/R3/R4/R5/R7: short frame, serial timebase, leading zeros
        cs_n = 1'b0; idle(2);
        result_in = 14'h2A5C;
        send_cmd(5, 8'b1_1_0_00_101);
        chk("R2 R4 port after cmd", int'(port_out), 5);
        chk("R3 unipolar", int'(cfg_unipolar), 1);
        run(24, 0);
        chk("R5 strobe at fall 7", int'(cap_s[7]), 1);
        chk("R5 strobe off at fall 8", int'(cap_s[8]), 0);
        chk("R5 strobe low at fall 6", int'(cap_s[6]), 0);
        chk("R7 short word", word_at(8), 'h2A5C);
        chk("R7 tail low", int'(cap_d[22] | cap_d[23]), 0);

        // R6/R12: long frame, din held high while busy
        result_in = 14'h1337;
        send_cmd(0, 8'b1_0_0_11_010);
        chk("R4 port long", int'(port_out), 2);
        run(32, 30);
        chk("R6 strobe at fall 15", int'(cap_s[15]), 1);
        chk("R6 strobe off at fall 16", int'(cap_s[16]), 0);
        chk("R6 long word", word_at(16), 'h1337);
        run(4, 0);
        chk("R12 no spurious strobe", int'(cap_s[1] | cap_s[2] | cap_s[3] | cap_s[4]), 0);
        chk("R12 port unchanged", int'(port_out), 2);

        // R8: calibration
        send_cmd(1, 8'b1_0_0_01_111);
        chk("R8 cal busy", int'(cal_busy), 1);
        chk("R4 port on cal", int'(port_out), 7);
        idle(CAL_C + 2);
        chk("R8 cal done", int'(cal_busy), 0);

        // R9: power-down then wake by conversion command
        send_cmd(0, 8'b1_0_0_10_001);
        chk("R9 pd set", int'(pwr_down), 1);
        idle(10);
        chk("R9 R4 port held in pd", int'(port_out), 1);
        result_in = 14'h0001;
        send_cmd(2, 8'b1_0_0_00_011);
        chk("R9 pd cleared", int'(pwr_down), 0);
        run(24, 0);
        chk("R7 lsb word", word_at(8), 'h0001);

        // R10: abort by deselect, then new acquisition
        result_in = 14'h3FFF;
        send_cmd(0, 8'b1_0_0_11_100);
        run(10, 0);
        cs_n = 1'b1; idle(2);
        chk("R10 strobe cleared", int'(strobe), 0);
        chk("R10 dout cleared", int'(dout), 0);
        cs_n = 1'b0; idle(2);
        result_in = 14'h2001;
        send_cmd(3, 8'b1_0_0_00_000);
        run(24, 0);
        chk("R10 new acquisition strobe", int'(cap_s[7]), 1);
        chk("R10 new acquisition word", word_at(8), 'h2001);

        // R11: internal timebase
        result_in = 14'h15AA;
        send_cmd(0, 8'b1_0_1_00_110);
        chk("R3 int clk", int'(cfg_int_clk), 1);
        chk("R11 strobe not yet", int'(strobe), 0);
        idle(INT_C + 3);
        chk("R11 strobe after count", int'(strobe), 1);
        run(17, 0);
        chk("R11 strobe cleared", int'(cap_s[1]), 0);
        chk("R11 int word", word_at(1), 'h15AA);
        chk("R11 tail low", int'(cap_d[15] | cap_d[16]), 0);

        cs_n = 1'b1; idle(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule